// File: doc/BRIEF.md
# I2C Bus Time-out Watchdog

This block watches an I2C protocol engine for stalls. While enabled, it counts peripheral clock cycles through a fixed divide-by-32 prescaler and compares the prescaled count against a 10-bit programmable limit. When the limit is passed, it sets a sticky time-out flag. If its enable bit is set, it also raises an interrupt line. The protocol engine sends a one-cycle pulse for every bus event it recognises, such as an acknowledge, a not-acknowledge, a start or a stop. Each pulse restarts the wait from zero, so the flag only appears when the bus stays silent for the whole programmed window.

Software clears the flag by writing one to it, which reaches the block as a single-cycle strobe. That strobe also restarts the count. When the time-out fires, the counter parks at zero and stops. It resumes only after a protocol event, a flag clear or a re-enable, so an unattended flag is not raised again every period. The block has no clock-source choice: it always runs from the peripheral clock. A debug output exposes the main counter.

Top module: `i2c_tmo_guard`

## Requirements
- R1: After reset, `tmo_flag`, `tmo_irq` and `dbg_count` are all zero.
- R2: With a limit value L, `tmo_flag` rises exactly (L+1)×32 clock edges after the restart edge, and is still low one edge earlier. The restart edge is the first edge at which `run_en` is seen high, or the edge that samples a `proto_evt` or `flag_clr` pulse. This holds at L = 0 and at L = 1023.
- R3: `dbg_count` counts up by one every 32 counting cycles and never exceeds L. After a restart it first becomes 1 at restart edge + 32.
- R4: Once set, `tmo_flag` stays at 1 until a `flag_clr` strobe. Protocol events, disabling and a further time-out leave it at 1.
- R5: A `flag_clr` strobe sampled at an edge makes `tmo_flag` 0 after that edge. It also restarts the count, so the next time-out comes (L+1)×32 edges later.
- R6: A `proto_evt` pulse sets `dbg_count` to 0 and restarts the window. Any time-out that the earlier window would have produced does not occur.
- R7: `tmo_irq` is 1 only when `tmo_flag` is 1 and `irq_en` was 1 at the same edge. With `irq_en` at 0, the flag still sets but `tmo_irq` stays 0.
- R8: While `run_en` is 0, the prescaler and `dbg_count` are held at zero and no time-out occurs.
- R9: After a time-out, `dbg_count` stays at 0 and no further counting happens until a protocol event, a flag clear or a re-enable.
- R10: If a `flag_clr` strobe and a time-out fall on the same edge, the clear wins. `tmo_flag` is 0 after that edge and a fresh window starts from that edge.
- R11: If a protocol event falls on the edge that would time out, the event wins. No flag is set and a fresh window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter enable; 0 holds the counter at zero |
| limit | input | 10 | Time-out limit L; the window is (L+1)×32 cycles |
| irq_en | input | 1 | Time-out interrupt enable |
| proto_evt | input | 1 | One-cycle pulse for each recognised bus event |
| flag_clr | input | 1 | One-cycle write-one-to-clear strobe for the flag |
| tmo_flag | output | 1 | Sticky time-out flag |
| tmo_irq | output | 1 | Time-out interrupt, flag gated by `irq_en` |
| dbg_count | output | 10 | Current main counter value |

## Verification
Two collisions can land on the edge where the window runs out: a software clear against a new time-out, and a bus event against a new time-out. The bench provokes each one by counting edges from a known restart. It schedules the clear or event strobe so that it is sampled on exactly the expiring edge. For each collision the bench expects the flag to stay low after that edge. It then expects a fresh full window measured from that same edge. A design where the time-out took priority would show the flag high one window too early.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

  localparam int unsigned TMO_LIMIT_W = 10;
  localparam int unsigned TMO_PRE_W   = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } tmo_state_e;

endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
  parameter int unsigned PRE_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic count_en,
  input  logic clear,
  output logic tick
);

  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else if (count_en) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = count_en && (pre_q == PRE_LAST);

  // R8: a cleared prescaler starts again from zero
  a_r8_pre_cleared: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pre_q == '0));

  // R3: the prescaler moves only while counting is allowed
  a_r3_pre_frozen: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !clear) |=> $stable(pre_q));

endmodule

// File: rtl/tmo_counter.sv
module tmo_counter #(
  parameter int unsigned CNT_W     = 10,
  parameter bit          REG_LIMIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_eff;
  logic             at_limit;

  generate
    if (REG_LIMIT) begin : g_lim_reg
      logic [CNT_W-1:0] lim_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lim_q <= '0;
        end else begin
          lim_q <= limit_i;
        end
      end
      assign lim_eff = lim_q;
    end else begin : g_lim_direct
      assign lim_eff = limit_i;
    end
  endgenerate

  assign at_limit = (cnt_q >= lim_eff);
  assign expire_o = tick && at_limit;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (at_limit) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  // R3: the count only changes on a prescaler tick or a clear
  a_r3_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_q) |-> $past(tick || clear));

  // R9: the count parks at zero after a time-out
  a_r9_park_zero: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/tmo_flag.sv
module tmo_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;
  logic irq_q;
  logic flag_d;

  always_comb begin
    if (clr_i) begin
      flag_d = 1'b0;
    end else if (set_i) begin
      flag_d = 1'b1;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d && irq_en;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R4: the flag is sticky without a clear
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);

  // R10: a clear strobe always leaves the flag low
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !flag_q);

  // R7: the interrupt follows the flag gated by the enable
  a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && $past(irq_en)));

endmodule

// File: rtl/i2c_tmo_guard.sv
module i2c_tmo_guard
  import tmo_pkg::*;
#(
  parameter int unsigned LIMIT_W   = TMO_LIMIT_W,
  parameter int unsigned PRE_W     = TMO_PRE_W,
  parameter bit          REG_LIMIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               irq_en,
  input  logic               proto_evt,
  input  logic               flag_clr,
  output logic               tmo_flag,
  output logic               tmo_irq,
  output logic [LIMIT_W-1:0] dbg_count
);

  tmo_state_e state_q;
  tmo_state_e state_d;

  logic restart;
  logic count_en;
  logic wipe;
  logic tick;
  logic expire;

  assign restart  = !run_en || proto_evt || flag_clr;
  assign count_en = (state_q == ST_RUN) && !restart;
  assign wipe     = restart || (state_q != ST_RUN);

  always_comb begin
    state_d = state_q;
    if (!run_en) begin
      state_d = ST_IDLE;
    end else if (proto_evt || flag_clr) begin
      state_d = ST_RUN;
    end else if (state_q == ST_IDLE) begin
      state_d = ST_RUN;
    end else if (expire) begin
      state_d = ST_HALT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  tmo_prescaler #(
    .PRE_W(PRE_W)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .count_en(count_en),
    .clear   (wipe),
    .tick    (tick)
  );

  tmo_counter #(
    .CNT_W    (LIMIT_W),
    .REG_LIMIT(REG_LIMIT)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (wipe),
    .tick    (tick),
    .limit_i (limit),
    .cnt_o   (dbg_count),
    .expire_o(expire)
  );

  tmo_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set_i (expire),
    .clr_i (flag_clr),
    .irq_en(irq_en),
    .flag_o(tmo_flag),
    .irq_o (tmo_irq)
  );

  // R8: disabled means the count is held at zero
  a_r8_disabled_zero: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (dbg_count == '0));

  // R6: a protocol event zeroes the count
  a_r6_event_zero: assert property (@(posedge clk) disable iff (rst)
    proto_evt |=> (dbg_count == '0));

  // R11: an event on the expiring edge suppresses the flag
  a_r11_event_no_set: assert property (@(posedge clk) disable iff (rst)
    (proto_evt && !tmo_flag) |=> !tmo_flag);

  // R9: while halted the count does not move
  a_r9_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && !restart) |=> $stable(dbg_count));

endmodule

// File: tb/sim_i2c_tmo_guard.sv
module sim_i2c_tmo_guard;

  localparam int unsigned LW = 10;
  localparam int unsigned WIN = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_en = 1'b0;
  logic [LW-1:0] limit = '0;
  logic          irq_en = 1'b0;
  logic          proto_evt = 1'b0;
  logic          flag_clr = 1'b0;
  logic          tmo_flag;
  logic          tmo_irq;
  logic [LW-1:0] dbg_count;

  always #2 clk = ~clk;

  i2c_tmo_guard u0 (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .limit    (limit),
    .irq_en   (irq_en),
    .proto_evt(proto_evt),
    .flag_clr (flag_clr),
    .tmo_flag (tmo_flag),
    .tmo_irq  (tmo_irq),
    .dbg_count(dbg_count)
  );

  typedef struct {
    int unsigned cyc;
    int          fl;
    int          irq;
    int          cnt;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int unsigned cyc = 0;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver side: schedule an expectation at an absolute edge index
  task automatic push_exp(input int unsigned at, input int fl, input int ir,
                          input int cn, input string tag);
    exp_t e;
    int   pos;
    e.cyc = at; e.fl = fl; e.irq = ir; e.cnt = cn; e.tag = tag;
    pos = sb_q.size();
    for (int i = 0; i < sb_q.size(); i++) begin
      if (sb_q[i].cyc > at) begin
        pos = i;
        break;
      end
    end
    sb_q.insert(pos, e);
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  // which: 0 = protocol event, 1 = flag clear; sampled at edge at_edge
  task automatic pulse_at(input bit which, input int unsigned at_edge);
    wait_until(at_edge - 1);
    if (which) flag_clr = 1'b1;
    else       proto_evt = 1'b1;
    @(negedge clk);
    flag_clr  = 1'b0;
    proto_evt = 1'b0;
  endtask

  // monitor side: pop and compare items as their cycle comes up
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (it.cyc != cyc) begin
        n_errors++;
        $display("FAIL %s: stale item for edge %0d at edge %0d", it.tag, it.cyc, cyc);
      end else if ((it.fl >= 0 && int'(tmo_flag) != it.fl) ||
                   (it.irq >= 0 && int'(tmo_irq) != it.irq) ||
                   (it.cnt >= 0 && int'(dbg_count) != it.cnt)) begin
        n_errors++;
        $display("FAIL %s @%0d: flag=%0d irq=%0d cnt=%0d expected flag=%0d irq=%0d cnt=%0d",
                 it.tag, cyc, tmo_flag, tmo_irq, dbg_count, it.fl, it.irq, it.cnt);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned e0;
    int unsigned e1;
    int unsigned e2;
    int unsigned p;

    limit  = 10'd2;
    irq_en = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    push_exp(cyc + 1, 0, 0, 0, "R1 reset state");
    @(negedge clk);
    @(negedge clk);

    // basic window with L=2
    p = 3 * WIN;
    e0 = cyc + 1;
    run_en = 1'b1;
    push_exp(e0 + 31, 0, 0, 0, "R3 no step before 32");
    push_exp(e0 + 32, 0, 0, 1, "R3 first step");
    push_exp(e0 + p - 1, 0, 0, 2, "R2 one edge early");
    push_exp(e0 + p, 1, 1, 0, "R2 R7 time-out with irq");
    push_exp(e0 + p + 50, 1, 1, 0, "R9 R4 parked after time-out");
    wait_until(e0 + p + 60);

    // software clear restarts the window
    e1 = cyc + 2;
    push_exp(e1, 0, 0, 0, "R5 clear drops flag");
    push_exp(e1 + p - 1, 0, 0, 2, "R5 restart early");
    push_exp(e1 + p, 1, 1, 0, "R5 restart window");
    pulse_at(1'b1, e1);
    wait_until(e1 + p + 5);

    // event in the middle moves the deadline
    e1 = cyc + 2;
    e2 = e1 + 50;
    push_exp(e1, 0, 0, 0, "R5 clear before event test");
    push_exp(e2, 0, 0, 0, "R6 event zeroes count");
    push_exp(e1 + p, 0, 0, -1, "R6 old deadline skipped");
    push_exp(e2 + p - 1, 0, 0, -1, "R6 new window early");
    push_exp(e2 + p, 1, 1, 0, "R6 new window");
    pulse_at(1'b1, e1);
    pulse_at(1'b0, e2);
    wait_until(e2 + p + 5);

    // event while flag set keeps the flag
    e1 = cyc + 2;
    push_exp(e1 + 3, 1, 1, 0, "R4 event leaves flag");
    pulse_at(1'b0, e1);
    wait_until(e1 + 10);

    // clear collides with a time-out
    e1 = cyc + 2;
    push_exp(e1, 0, 0, 0, "R10 setup clear");
    push_exp(e1 + p, 0, 0, 0, "R10 clear beats time-out");
    push_exp(e1 + 2 * p - 1, 0, 0, 2, "R10 fresh window early");
    push_exp(e1 + 2 * p, 1, 1, 0, "R10 fresh window");
    pulse_at(1'b1, e1);
    pulse_at(1'b1, e1 + p);
    wait_until(e1 + 2 * p + 5);

    // event collides with a time-out
    e1 = cyc + 2;
    push_exp(e1 + p, 0, 0, 0, "R11 event beats time-out");
    push_exp(e1 + 2 * p - 1, 0, 0, 2, "R11 fresh window early");
    push_exp(e1 + 2 * p, 1, 1, 0, "R11 fresh window");
    pulse_at(1'b1, e1);
    pulse_at(1'b0, e1 + p);
    wait_until(e1 + 2 * p + 5);

    // interrupt gating
    irq_en = 1'b0;
    push_exp(cyc + 1, 1, 0, -1, "R7 irq masked");
    @(negedge clk);
    @(negedge clk);
    irq_en = 1'b1;
    push_exp(cyc + 1, 1, 1, -1, "R7 irq unmasked");
    @(negedge clk);
    @(negedge clk);

    // disable holds zero, flag survives, limit 0
    run_en = 1'b0;
    limit  = 10'd0;
    push_exp(cyc + 1, 1, 1, 0, "R4 R8 disable keeps flag");
    @(negedge clk);
    e1 = cyc + 2;
    push_exp(e1, 0, 0, 0, "R5 clear while disabled");
    push_exp(e1 + 150, 0, 0, 0, "R8 no time-out while disabled");
    pulse_at(1'b1, e1);
    wait_until(e1 + 155);
    e0 = cyc + 1;
    run_en = 1'b1;
    push_exp(e0 + 31, 0, 0, 0, "R2 L0 early");
    push_exp(e0 + 32, 1, 1, 0, "R2 L0 window");
    wait_until(e0 + 40);

    // maximum limit
    limit = 10'd1023;
    p = 1024 * WIN;
    e1 = cyc + 3;
    push_exp(e1, 0, 0, 0, "R5 clear before max test");
    push_exp(e1 + 16 * WIN, 0, 0, 16, "R3 count at max limit");
    push_exp(e1 + p - 1, 0, 0, 1023, "R2 R3 max early");
    push_exp(e1 + p, 1, 1, 0, "R2 max window");
    pulse_at(1'b1, e1);
    wait_until(e1 + p + 4);

    if (sb_q.size() != 0) begin
      n_checks++;
      n_errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule